// File: doc/BRIEF.md
# Serial Status Flag Register with Sequenced Clear

This block keeps the nine event flags of a serial communications interface in one 16-bit status word. Pulses from the transmitter and receiver set the flags. Software clears them in two steps. First it reads the status word. Then it reads or writes the data location. When the status word is read, the block records which flags were set at that moment. The later data access clears only those recorded flags, so an event that arrives between the two steps is not lost.

A combined long-word read returns the status word and clears only the receive-side flags that were set at that time. The two transmitter flags stay untouched by it. The transmitter raises those two flags through set pulses and drops them through dedicated hardware clear inputs. The shifters, the baud logic and the data buffers live elsewhere and appear here only as pulse inputs.

The bus side is one access per cycle. A valid strobe, a write flag and a 2-bit select pick the target: status high byte, status low byte, data, or long-word. Read results come back one cycle later on a registered port.

Top module: `serstat_flags`

## Requirements
- R1: The status word places PF at bit 0, FE at 1, NF at 2, OR at 3, IDLE at 4, RAF at 5, RDRF at 6, TC at 7 and TDRE at 8, and bits 15:9 read as zero. A read returns its word on `rd_data` with `rd_valid` high, one cycle after the access. A data read returns zero.
- R2: After reset the flags are 0x180 (TDRE and TC set, all others clear).
- R3: A pulse on bit i of `set_evt` makes flag i read 1 after the next clock edge.
- R4: A status read (select 0 or 1, read) records the flags set at that moment and replaces any earlier record. A following data access (select 2, read or write) clears exactly the recorded flags and consumes the record.
- R5: A flag set after the status read but before the data access stays set. It clears only after a fresh status read sees it and another data access follows.
- R6: A data access with no unconsumed status read leaves every flag unchanged. This includes a second data access after a clearing one.
- R7: A long-word read (select 3, read) returns the status word and clears flags 6:0 that are set at that time. It never clears TDRE or TC, and it discards any pending record.
- R8: `clr_txfree` clears TDRE and `clr_txidle` clears TC at the next edge, whatever the access sequence is doing.
- R9: When a set pulse and any clear hit the same flag in the same cycle, the flag ends up set.
- R10: Writes with select 0, 1 or 3 have no effect on the flags and do not arm a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Bus access strobe for this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 2 | 0 status high byte, 1 status low byte, 2 data, 3 long-word |
| set_evt | input | NFLAG | Per-flag set pulses from transmitter and receiver |
| clr_txfree | input | 1 | Hardware clear of TDRE (data loaded) |
| clr_txidle | input | 1 | Hardware clear of TC (transmitter busy) |
| flags | output | NFLAG | Current flag register |
| rd_data | output | DW | Registered read data |
| rd_valid | output | 1 | Read data valid |

## Verification
The bench builds the block with its default parameters: nine flags in a 16-bit word. With these values the two transmitter bits sit at the top of the implemented field and the unimplemented bits 15:9 are visible on the read port. This lets the bench observe the boundary between receive-side and transmit-side clearing on a long-word read, and the zero padding, directly at the ports. The bench runs one access at a time through a reference model of flags and record. The hard case is a set pulse that lands between the status read and the data access, or in the same cycle as a clear.

// File: rtl/serstat_pkg.sv
package serstat_pkg;
  typedef enum logic [1:0] {
    SEL_STAT_HI = 2'd0,
    SEL_STAT_LO = 2'd1,
    SEL_DATA    = 2'd2,
    SEL_LONG    = 2'd3
  } acc_sel_e;
endpackage

// File: rtl/serstat_decode.sv
module serstat_decode
  import serstat_pkg::*;
(
  input  logic       acc_valid,
  input  logic       acc_write,
  input  logic [1:0] acc_sel,
  output logic       stat_rd,
  output logic       data_acc,
  output logic       data_rd,
  output logic       long_rd
);
  acc_sel_e sel;

  always_comb begin
    sel      = acc_sel_e'(acc_sel);
    stat_rd  = acc_valid && !acc_write && (sel == SEL_STAT_HI || sel == SEL_STAT_LO);
    data_acc = acc_valid && (sel == SEL_DATA);
    data_rd  = data_acc && !acc_write;
    long_rd  = acc_valid && !acc_write && (sel == SEL_LONG);
  end
endmodule

// File: rtl/serstat_arm.sv
module serstat_arm #(
  parameter int NFLAG = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stat_rd,
  input  logic             data_acc,
  input  logic             long_rd,
  input  logic [NFLAG-1:0] flags_q,
  output logic [NFLAG-1:0] seq_clr
);
  logic [NFLAG-1:0] arm_q;

  // the record is spent by the data access that uses it
  always_comb seq_clr = data_acc ? arm_q : '0;

  always_ff @(posedge clk) begin
    if (rst)
      arm_q <= '0;
    else if (stat_rd)
      arm_q <= flags_q;
    else if (data_acc || long_rd)
      arm_q <= '0;
  end
endmodule

// File: rtl/serstat_bank.sv
module serstat_bank #(
  parameter int               NFLAG   = 9,
  parameter logic [NFLAG-1:0] RST_VAL = '0,
  parameter logic [NFLAG-1:0] RX_MASK = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] set_evt,
  input  logic [NFLAG-1:0] seq_clr,
  input  logic             long_rd,
  input  logic             clr_txfree,
  input  logic             clr_txidle,
  output logic [NFLAG-1:0] flags_q
);
  localparam int TXFREE_BIT = NFLAG - 1;
  localparam int TXIDLE_BIT = NFLAG - 2;

  logic [NFLAG-1:0] long_clr;
  logic [NFLAG-1:0] hw_clr;

  always_comb long_clr = long_rd ? (flags_q & RX_MASK) : '0;

  for (genvar i = 0; i < NFLAG; i++) begin : g_bit
    if (i == TXFREE_BIT) begin : g_txfree
      assign hw_clr[i] = clr_txfree;
    end else if (i == TXIDLE_BIT) begin : g_txidle
      assign hw_clr[i] = clr_txidle;
    end else begin : g_rx
      assign hw_clr[i] = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (rst)
        flags_q[i] <= RST_VAL[i];
      else if (set_evt[i])
        flags_q[i] <= 1'b1;
      else if (seq_clr[i] || long_clr[i] || hw_clr[i])
        flags_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/serstat_rdport.sv
module serstat_rdport #(
  parameter int NFLAG = 9,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stat_rd,
  input  logic             long_rd,
  input  logic             data_rd,
  input  logic [NFLAG-1:0] flags_q,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid
);
  localparam int PAD = DW - NFLAG;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= stat_rd || long_rd || data_rd;
      if (stat_rd || long_rd)
        rd_data <= {{PAD{1'b0}}, flags_q};
      else
        rd_data <= '0;
    end
  end
endmodule

// File: rtl/serstat_flags.sv
module serstat_flags #(
  parameter int NFLAG = 9,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [1:0]       acc_sel,
  input  logic [NFLAG-1:0] set_evt,
  input  logic             clr_txfree,
  input  logic             clr_txidle,
  output logic [NFLAG-1:0] flags,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid
);
  localparam int               NRX     = NFLAG - 2;
  localparam logic [NFLAG-1:0] RX_MASK = {2'b00, {NRX{1'b1}}};
  localparam logic [NFLAG-1:0] RST_VAL = {2'b11, {NRX{1'b0}}};

  logic             stat_rd, data_acc, data_rd, long_rd;
  logic [NFLAG-1:0] seq_clr;
  logic [NFLAG-1:0] flags_q;

  serstat_decode u_dec (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_sel   (acc_sel),
    .stat_rd   (stat_rd),
    .data_acc  (data_acc),
    .data_rd   (data_rd),
    .long_rd   (long_rd)
  );

  serstat_arm #(.NFLAG(NFLAG)) u_arm (
    .clk      (clk),
    .rst      (rst),
    .stat_rd  (stat_rd),
    .data_acc (data_acc),
    .long_rd  (long_rd),
    .flags_q  (flags_q),
    .seq_clr  (seq_clr)
  );

  serstat_bank #(.NFLAG(NFLAG), .RST_VAL(RST_VAL), .RX_MASK(RX_MASK)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .set_evt    (set_evt),
    .seq_clr    (seq_clr),
    .long_rd    (long_rd),
    .clr_txfree (clr_txfree),
    .clr_txidle (clr_txidle),
    .flags_q    (flags_q)
  );

  serstat_rdport #(.NFLAG(NFLAG), .DW(DW)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .stat_rd  (stat_rd),
    .long_rd  (long_rd),
    .data_rd  (data_rd),
    .flags_q  (flags_q),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  assign flags = flags_q;
endmodule

// File: rtl/serstat_flags_chk.sv
module serstat_flags_chk #(
  parameter int NFLAG = 9,
  parameter int DW    = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_valid,
  input logic             acc_write,
  input logic [1:0]       acc_sel,
  input logic [NFLAG-1:0] set_evt,
  input logic             clr_txfree,
  input logic             clr_txidle,
  input logic [NFLAG-1:0] flags,
  input logic [DW-1:0]    rd_data,
  input logic             rd_valid
);
  localparam logic [NFLAG-1:0] RST_VAL = {2'b11, {(NFLAG-2){1'b0}}};

  logic any_clear_path;
  logic long_rd_c;
  always_comb begin
    any_clear_path = (acc_valid && (acc_sel == 2'd2 || (acc_sel == 2'd3 && !acc_write)))
                     || clr_txfree || clr_txidle;
    long_rd_c      = acc_valid && !acc_write && acc_sel == 2'd3;
  end

  a_r1_pad_zero: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rd_data[DW-1:NFLAG] == '0);

  a_r2_reset_value: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> flags == RST_VAL);

  a_r3_set_lands: assert property (@(posedge clk) disable iff (rst)
    (set_evt != '0) |=> ((flags & $past(set_evt)) == $past(set_evt)));

  a_r6_no_spurious_clear: assert property (@(posedge clk) disable iff (rst)
    !any_clear_path |=> ((flags & $past(flags)) == $past(flags)));

  a_r7_long_keeps_tx: assert property (@(posedge clk) disable iff (rst)
    (long_rd_c && !clr_txfree && !clr_txidle) |=>
      ((flags[NFLAG-1:NFLAG-2] & $past(flags[NFLAG-1:NFLAG-2])) == $past(flags[NFLAG-1:NFLAG-2])));

  a_r8_hw_clear_txfree: assert property (@(posedge clk) disable iff (rst)
    (clr_txfree && !set_evt[NFLAG-1]) |=> !flags[NFLAG-1]);

  a_r8_hw_clear_txidle: assert property (@(posedge clk) disable iff (rst)
    (clr_txidle && !set_evt[NFLAG-2]) |=> !flags[NFLAG-2]);
endmodule

bind serstat_flags serstat_flags_chk #(.NFLAG(NFLAG), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .acc_valid  (acc_valid),
  .acc_write  (acc_write),
  .acc_sel    (acc_sel),
  .set_evt    (set_evt),
  .clr_txfree (clr_txfree),
  .clr_txidle (clr_txidle),
  .flags      (flags),
  .rd_data    (rd_data),
  .rd_valid   (rd_valid)
);

// File: tb/sim_serstat_flags.sv
`timescale 1ns/1ps
module sim_serstat_flags;
  localparam int NFLAG = 9;
  localparam int DW    = 16;
  localparam logic [NFLAG-1:0] RXM = 9'h07F;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             acc_valid = 1'b0, acc_write = 1'b0;
  logic [1:0]       acc_sel = 2'd0;
  logic [NFLAG-1:0] set_evt = '0;
  logic             clr_txfree = 1'b0, clr_txidle = 1'b0;
  logic [NFLAG-1:0] flags;
  logic [DW-1:0]    rd_data;
  logic             rd_valid;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [NFLAG-1:0] mf, ms;
  logic [DW-1:0]    exp_q[$];
  string            tag_q[$];

  always #2.5 clk = ~clk;

  serstat_flags #(.NFLAG(NFLAG), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_sel(acc_sel), .set_evt(set_evt), .clr_txfree(clr_txfree),
    .clr_txidle(clr_txidle), .flags(flags), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // monitor: pops expected read words as the design returns them
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R1 unexpected read: actual %h expected none", rd_data);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          fails++;
          $display("FAIL %s read word: actual %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic op(input bit v, input bit w, input logic [1:0] sel,
                    input logic [NFLAG-1:0] set, input bit hf, input bit hi,
                    input string tag);
    logic [NFLAG-1:0] clr;
    bit sr, da, lw;
    @(negedge clk);
    acc_valid = v; acc_write = w; acc_sel = sel;
    set_evt = set; clr_txfree = hf; clr_txidle = hi;
    sr = v && !w && (sel == 2'd0 || sel == 2'd1);
    da = v && (sel == 2'd2);
    lw = v && !w && (sel == 2'd3);
    clr = '0;
    if (da) clr |= ms;
    if (lw) clr |= mf & RXM;
    if (hf) clr[8] = 1'b1;
    if (hi) clr[7] = 1'b1;
    if (sr || lw) begin exp_q.push_back({7'b0, mf}); tag_q.push_back(tag); end
    if (da && !w) begin exp_q.push_back('0); tag_q.push_back(tag); end
    if (sr) ms = mf;
    else if (da || lw) ms = '0;
    mf = (mf & ~clr) | set;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; acc_sel = 2'd0;
    set_evt = '0; clr_txfree = 1'b0; clr_txidle = 1'b0;
  endtask

  task automatic idle(input logic [NFLAG-1:0] set, input string tag);
    op(1'b0, 1'b0, 2'd0, set, 1'b0, 1'b0, tag);
  endtask

  task automatic chk(input string tag);
    checks++;
    if (flags !== mf) begin
      fails++;
      $display("FAIL %s flags: actual %h expected %h", tag, flags, mf);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    mf = 9'h180; ms = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R2");                                        // reset value 0x180
    op(1, 0, 2'd1, '0, 0, 0, "R1"); chk("R1");        // status low byte read
    // R3 set pulses, R4 clear through read then data read
    idle(9'h048, "R3"); chk("R3");
    op(1, 0, 2'd0, '0, 0, 0, "R4"); chk("R4");
    op(1, 0, 2'd2, '0, 0, 0, "R4"); chk("R4");        // flags now 0
    // R6 second data access with no new read
    idle(9'h002, "R3");
    op(1, 1, 2'd2, '0, 0, 0, "R6"); chk("R6");
    // R5 late arrival survives
    op(1, 0, 2'd1, '0, 0, 0, "R5");
    idle(9'h004, "R5");
    op(1, 1, 2'd2, '0, 0, 0, "R5"); chk("R5");        // FE cleared, NF stays
    op(1, 1, 2'd2, '0, 0, 0, "R6"); chk("R6");        // record spent
    op(1, 0, 2'd0, '0, 0, 0, "R5");
    op(1, 0, 2'd2, '0, 0, 0, "R5"); chk("R5");
    // R4 a new status read replaces the record
    idle(9'h001, "R4");
    op(1, 0, 2'd0, '0, 0, 0, "R4");
    idle(9'h010, "R4");
    op(1, 0, 2'd1, '0, 0, 0, "R4");
    op(1, 1, 2'd2, '0, 0, 0, "R4"); chk("R4");
    // R7 long-word read
    idle(9'h1E5, "R3"); chk("R3");
    op(1, 0, 2'd1, '0, 0, 0, "R7");
    op(1, 0, 2'd3, '0, 0, 0, "R7"); chk("R7");        // rx gone, tx stays
    op(1, 0, 2'd2, '0, 0, 0, "R7"); chk("R7");        // record discarded
    // R8 hardware clears
    op(0, 0, 2'd0, '0, 1, 0, "R8"); chk("R8");
    op(0, 0, 2'd0, '0, 0, 1, "R8"); chk("R8");
    // R9 set beats clears
    idle(9'h1C0, "R9");
    op(1, 0, 2'd0, '0, 0, 0, "R9");
    op(1, 0, 2'd2, 9'h040, 1, 0, "R9"); chk("R9");
    op(0, 0, 2'd0, 9'h100, 1, 0, "R9"); chk("R9");
    op(1, 0, 2'd3, 9'h040, 0, 0, "R9"); chk("R9");
    // R10 writes to status or long select do nothing
    idle(9'h00A, "R10");
    op(1, 1, 2'd0, '0, 0, 0, "R10"); chk("R10");
    op(1, 1, 2'd3, '0, 0, 0, "R10"); chk("R10");
    op(1, 1, 2'd2, '0, 0, 0, "R10"); chk("R10");
    op(1, 0, 2'd1, '0, 0, 0, "R1"); chk("R1");
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R1 missing reads: actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule